// File: doc/BRIEF.md
# Optical Front-End Bring-Up and Readout Sequencer

This block sits on the host side of an optical sensor front-end and controls it over a four-wire SPI link. After a single start pulse it runs a fixed bring-up. It pulses the device's soft-reset bit, turns on self-diagnosis, opens register read-back and reads the diagnosis word. If that word is clean, it closes read-back, loads the timing and control registers from a constant table held inside the block, and opens read-back again. From then on, every rising edge on the data-ready input makes the block read the six result registers. The six sign-extended codes are then offered together on a parallel stream output.

The result output is a valid/ready stream. Once `res_valid_o` is high, it and `res_data_o` stay unchanged until a cycle in which `res_ready_i` is also high. While a result set is waiting to be accepted, no new readout is started. A data-ready edge that arrives while a readout is running, or while a set is being held, is counted as an overrun and is otherwise dropped. A nonzero diagnosis word halts the sequence for good, until reset.

Top module: `optic_fe_bringup`

## Requirements
- R1: While `rst_n_i` is low and after it is released, `cs_n_o` is 1, `sclk_o` is 0, `fault_o` is 0, `res_valid_o` is 0 and `ovr_cnt_o` is 0.
- R2: Every SPI frame keeps `cs_n_o` low for exactly 32 SCLK rising edges and carries an 8-bit address followed by a 24-bit data word, MSB first. `mosi_o` changes only after falling SCLK edges, and `miso_i` is sampled on rising edges. SCLK idles low, and each SCLK phase lasts `HALF_DIV` clock cycles.
- R3: The device control register is at address 0x00, with bit 3 = soft reset, bit 2 = diagnosis enable and bit 0 = read-back enable. The first four frames are writes of 0x000008, 0x000004 and 0x000001 to address 0x00, followed by a read of the diagnosis address (default 0x30). A read frame carries zero in its data field.
- R4: When the diagnosis word is zero, the next frames are a write of 0x000000 to 0x00 and then 34 configuration writes. Entry i (0..33) goes to address i+1 for i<30 (0x01..0x1E) and to i+2 otherwise (0x20..0x23). Its data is {low byte of 7*i+3, address, 0xC0 XOR i}. The last frame is a write of 0x000001 to 0x00, for 40 bring-up frames in all.
- R5: When the diagnosis word is nonzero, `fault_o` rises and stays high, `diag_word_o` shows the word, and no further frame is sent until reset.
- R6: After bring-up, each rising edge of `drdy_i` starts six reads at addresses 0x2A, 0x2B, ... 0x2F, in that order. Data-ready edges before the end of bring-up are ignored and are not counted.
- R7: In `res_data_o`, field k (bits 24k+23 down to 24k) holds the word read from address 0x2A+k, sign-extended from its bit 21. Bits 23 and 22 of the received word are discarded.
- R8: `res_valid_o` rises after the sixth read. While it is high and `res_ready_i` is low, valid and data hold steady and no frame is sent. It falls after the first cycle with `res_ready_i` high.
- R9: A data-ready edge that arrives during a readout or while a result set is held increments `ovr_cnt_o` (saturating) and does not start or restart a readout.
- R10: `start_i` is acted on only before the first start after reset. A later start neither restarts nor alters the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin bring-up (pulse) |
| drdy_i | input | 1 | Data-ready from the device, rising edge active |
| sclk_o | output | 1 | SPI clock |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to device |
| miso_i | input | 1 | SPI data from device |
| fault_o | output | 1 | Diagnosis reported a fault; sequence halted |
| diag_word_o | output | 24 | Diagnosis word as read |
| ovr_cnt_o | output | OVR_W (8) | Saturating count of overrun data-ready edges |
| res_valid_o | output | 1 | Result set valid |
| res_ready_i | input | 1 | Result set accepted |
| res_data_o | output | 6*24 (144) | Six sign-extended result codes, field 0 lowest |

## Verification
A behavioural device model on the SPI pins logs each frame's address and data. The bring-up log is compared frame by frame with the table computed from R3 and R4, which catches a wrong order, a wrong bit position or a skipped address. Readouts are driven from a table of raw words. The table mixes positive and negative 22-bit codes with junk in bits 23 and 22, so a missing sign extension or a swapped field shows up. One readout is held under back-pressure and another is hit by an early data-ready edge, which tells overrun counting apart from restarting. A separate run returns a nonzero diagnosis word and checks that no configuration frame follows.

// File: rtl/ofb_pkg.sv
package ofb_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 24;
  localparam int FRAME_W   = ADDR_W + DATA_W;
  localparam int CODE_W    = 22;
  localparam int CFG_N     = 34;
  localparam int PRE_STEPS = 5;
  localparam int BOOT_N    = CFG_N + PRE_STEPS + 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h00;
  localparam logic [ADDR_W-1:0] CFG_HOLE  = 8'h1F;
  localparam int BIT_RST  = 3;
  localparam int BIT_DIAG = 2;
  localparam int BIT_RDEN = 0;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  function automatic logic [ADDR_W-1:0] cfg_addr(int idx);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(idx + 1);
    if (a >= CFG_HOLE) a = a + 1'b1;
    return a;
  endfunction

  function automatic frame_t boot_frame(int s, logic [ADDR_W-1:0] diag);
    frame_t f;
    int idx;
    f   = '0;
    idx = s - PRE_STEPS;
    f.addr = CTRL_ADDR;
    if (s == 0)      f.data[BIT_RST]  = 1'b1;
    else if (s == 1) f.data[BIT_DIAG] = 1'b1;
    else if (s == 2) f.data[BIT_RDEN] = 1'b1;
    else if (s == 3) begin
      f.rd   = 1'b1;
      f.addr = diag;
    end else if (s == 4) f.data = '0;
    else if (idx < CFG_N) begin
      f.addr = cfg_addr(idx);
      f.data = {8'(idx * 7 + 3), cfg_addr(idx), 8'hC0 ^ 8'(idx)};
    end else f.data[BIT_RDEN] = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/ofb_spi_master.sv
module ofb_spi_master #(
  parameter int HALF_DIV = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_n_i,
  input  logic                         start_i,
  input  logic [ofb_pkg::FRAME_W-1:0]  tx_i,
  output logic                         done_o,
  output logic [ofb_pkg::DATA_W-1:0]   rx_o,
  output logic                         sclk_o,
  output logic                         cs_n_o,
  output logic                         mosi_o,
  input  logic                         miso_i
);
  import ofb_pkg::*;
  localparam int DIV_W = $clog2(HALF_DIV) + 1;
  localparam int CNT_W = $clog2(FRAME_W) + 1;

  logic [FRAME_W-1:0] tx_q;
  logic [DATA_W-1:0]  rx_q;
  logic [DIV_W-1:0]   div_q;
  logic [CNT_W-1:0]   fall_q;
  logic               busy_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      tx_q <= '0; rx_q <= '0; div_q <= '0; fall_q <= '0;
      busy_q <= 1'b0; sclk_q <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          tx_q   <= tx_i;
          div_q  <= '0;
          fall_q <= '0;
          sclk_q <= 1'b0;
        end
      end else if (div_q == DIV_W'(HALF_DIV - 1)) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
        if (!sclk_q) begin
          rx_q <= {rx_q[DATA_W-2:0], miso_i};
        end else begin
          tx_q   <= {tx_q[FRAME_W-2:0], 1'b0};
          fall_q <= fall_q + 1'b1;
          if (fall_q == CNT_W'(FRAME_W - 1)) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign cs_n_o = ~busy_q;
  assign mosi_o = tx_q[FRAME_W-1];
  assign rx_o   = rx_q;

  assert_idle_clk_low_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cs_n_o |-> !sclk_o);
  assert_mosi_steady_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(sclk_o) |-> $stable(mosi_o));
endmodule

// File: rtl/ofb_boot_rom.sv
module ofb_boot_rom #(
  parameter logic [7:0] DIAG_ADDR = 8'h30,
  parameter int         STEP_W    = 6
) (
  input  logic [STEP_W-1:0] step_i,
  output ofb_pkg::frame_t   frame_o
);
  import ofb_pkg::*;
  frame_t table_w [BOOT_N];

  for (genvar g = 0; g < BOOT_N; g++) begin : g_ent
    assign table_w[g] = boot_frame(g, DIAG_ADDR);
  end

  always_comb begin
    frame_o = '0;
    if (step_i < STEP_W'(BOOT_N)) frame_o = table_w[step_i];
  end
endmodule

// File: rtl/optic_fe_bringup.sv
module optic_fe_bringup #(
  parameter int         HALF_DIV  = 2,
  parameter int         N_RES     = 6,
  parameter int         OVR_W     = 8,
  parameter logic [7:0] DIAG_ADDR = 8'h30,
  parameter logic [7:0] RES_BASE  = 8'h2A
) (
  input  logic                         clk_i,
  input  logic                         rst_n_i,
  input  logic                         start_i,
  input  logic                         drdy_i,
  output logic                         sclk_o,
  output logic                         cs_n_o,
  output logic                         mosi_o,
  input  logic                         miso_i,
  output logic                         fault_o,
  output logic [23:0]                  diag_word_o,
  output logic [OVR_W-1:0]             ovr_cnt_o,
  output logic                         res_valid_o,
  input  logic                         res_ready_i,
  output logic [N_RES*24-1:0]          res_data_o
);
  import ofb_pkg::*;
  localparam int STEP_W = $clog2(BOOT_N);
  localparam int RIDX_W = $clog2(N_RES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_BOOT_GO, ST_BOOT_WAIT, ST_FAULT,
    ST_STREAM, ST_RD_GO, ST_RD_WAIT, ST_HOLD
  } state_t;

  state_t              st_q;
  logic [STEP_W-1:0]   step_q;
  logic [RIDX_W-1:0]   ridx_q;
  logic [DATA_W-1:0]   res_q [N_RES];
  logic [DATA_W-1:0]   diag_q;
  logic [OVR_W-1:0]    ovr_q;
  logic                drdy_q;
  logic                drdy_edge;
  logic                spi_go, spi_done;
  logic [FRAME_W-1:0]  spi_tx;
  logic [DATA_W-1:0]   spi_rx;
  frame_t              boot_w;
  logic                busy_rd;

  ofb_boot_rom #(.DIAG_ADDR(DIAG_ADDR), .STEP_W(STEP_W)) u_rom (
    .step_i(step_q), .frame_o(boot_w));

  ofb_spi_master #(.HALF_DIV(HALF_DIV)) u_spi (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .start_i(spi_go), .tx_i(spi_tx),
    .done_o(spi_done), .rx_o(spi_rx), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
    .mosi_o(mosi_o), .miso_i(miso_i));

  assign drdy_edge = drdy_i & ~drdy_q;
  assign spi_go    = (st_q == ST_BOOT_GO) || (st_q == ST_RD_GO);
  assign spi_tx    = (st_q == ST_RD_GO) ? {RES_BASE + ADDR_W'(ridx_q), {DATA_W{1'b0}}}
                                        : {boot_w.addr, boot_w.data};
  assign busy_rd   = (st_q == ST_RD_GO) || (st_q == ST_RD_WAIT) || (st_q == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q <= ST_IDLE; step_q <= '0; ridx_q <= '0; diag_q <= '0;
      ovr_q <= '0; drdy_q <= 1'b0;
      for (int i = 0; i < N_RES; i++) res_q[i] <= '0;
    end else begin
      drdy_q <= drdy_i;
      if (drdy_edge && busy_rd && (ovr_q != {OVR_W{1'b1}})) ovr_q <= ovr_q + 1'b1;
      unique case (st_q)
        ST_IDLE:    if (start_i) begin st_q <= ST_BOOT_GO; step_q <= '0; end
        ST_BOOT_GO: st_q <= ST_BOOT_WAIT;
        ST_BOOT_WAIT: if (spi_done) begin
          if (boot_w.rd) diag_q <= spi_rx;
          if (boot_w.rd && (spi_rx != '0)) st_q <= ST_FAULT;
          else if (step_q == STEP_W'(BOOT_N - 1)) st_q <= ST_STREAM;
          else begin
            step_q <= step_q + 1'b1;
            st_q   <= ST_BOOT_GO;
          end
        end
        ST_FAULT:   st_q <= ST_FAULT;
        ST_STREAM:  if (drdy_edge) begin st_q <= ST_RD_GO; ridx_q <= '0; end
        ST_RD_GO:   st_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (spi_done) begin
          res_q[ridx_q] <= {{(DATA_W-CODE_W){spi_rx[CODE_W-1]}}, spi_rx[CODE_W-1:0]};
          if (ridx_q == RIDX_W'(N_RES - 1)) st_q <= ST_HOLD;
          else begin
            ridx_q <= ridx_q + 1'b1;
            st_q   <= ST_RD_GO;
          end
        end
        ST_HOLD:    if (res_ready_i) st_q <= ST_STREAM;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < N_RES; g++) begin : g_pack
    assign res_data_o[g*DATA_W +: DATA_W] = res_q[g];
  end

  assign fault_o     = (st_q == ST_FAULT);
  assign diag_word_o = diag_q;
  assign ovr_cnt_o   = ovr_q;
  assign res_valid_o = (st_q == ST_HOLD);

  assert_hold_steady_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));
  assert_hold_no_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    res_valid_o |-> cs_n_o);
  assert_fault_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fault_o |=> fault_o);
  assert_fault_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fault_o |-> cs_n_o);
  assert_ovr_monotonic_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ovr_cnt_o >= $past(ovr_cnt_o));
endmodule

// File: tb/sim_optic_fe_bringup.sv
module sim_optic_fe_bringup;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, drdy = 1'b0, miso = 1'b0, rdy = 1'b0;
  logic sclk, cs_n, mosi, fault, valid;
  logic [23:0]  diag_word;
  logic [7:0]   ovr;
  logic [143:0] rdata;

  always #2 clk = ~clk;

  optic_fe_bringup u0 (
    .clk_i(clk), .rst_n_i(rst_n), .start_i(start), .drdy_i(drdy),
    .sclk_o(sclk), .cs_n_o(cs_n), .mosi_o(mosi), .miso_i(miso),
    .fault_o(fault), .diag_word_o(diag_word), .ovr_cnt_o(ovr),
    .res_valid_o(valid), .res_ready_i(rdy), .res_data_o(rdata));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0, armed = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [143:0] act, input logic [143:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // raw word returned by device, expected sign-extended field
  localparam logic [47:0] VEC [8] = '{
    {24'h000001, 24'h000001}, {24'h1FFFFF, 24'h1FFFFF},
    {24'h200000, 24'hE00000}, {24'h3FFFFF, 24'hFFFFFF},
    {24'hC00005, 24'h000005}, {24'h7ABCDE, 24'hFABCDE},
    {24'h955555, 24'h155555}, {24'h2AAAAA, 24'hEAAAAA}};

  // behavioural device
  int          bitc = 0;
  int          nfr = 0;
  logic [31:0] sh = '0;
  logic [7:0]  cur_addr = '0;
  logic [31:0] flog [64];
  logic [23:0] diag_val = '0;
  logic [23:0] res_val [6];

  function automatic logic [23:0] dev_word(input logic [7:0] a);
    if (a == 8'h30) return diag_val;
    if (a >= 8'h2A && a <= 8'h2F) return res_val[a - 8'h2A];
    return 24'h0;
  endfunction

  always @(negedge cs_n) begin bitc = 0; sh = '0; miso = 1'b0; end
  always @(posedge sclk) if (!cs_n) begin
    sh = {sh[30:0], mosi};
    bitc++;
    if (bitc == 8) cur_addr = sh[7:0];
  end
  always @(negedge sclk) if (!cs_n && bitc >= 8 && bitc < 32) begin
    logic [23:0] w;
    w = dev_word(cur_addr);
    miso = w[31 - bitc];
  end
  always @(posedge cs_n) if (armed) begin
    chk(bitc == 32, "R2 frame length", 144'(bitc), 144'd32);
    if (nfr < 64) flog[nfr] = sh;
    nfr++;
  end

  function automatic logic [31:0] exp_boot(input int s);
    int i;
    logic [7:0] a;
    i = s - 5;
    if (s == 0) return {8'h00, 24'h000008};
    if (s == 1) return {8'h00, 24'h000004};
    if (s == 2) return {8'h00, 24'h000001};
    if (s == 3) return {8'h30, 24'h000000};
    if (s == 4) return {8'h00, 24'h000000};
    if (s == 39) return {8'h00, 24'h000001};
    a = (i < 30) ? 8'(i + 1) : 8'(i + 2);
    return {a, 8'(i * 7 + 3), a, 8'hC0 ^ 8'(i)};
  endfunction

  task automatic pulse_drdy();
    @(negedge clk) drdy = 1'b1;
    @(negedge clk) drdy = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int t = 0;
    while (nfr < n && t < 20000) begin @(negedge clk); t++; end
    chk(nfr >= n, "R2 frames arrive", 144'(nfr), 144'(n));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; armed = 1'b0;
    repeat (5) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1 spi idle in reset", {cs_n, sclk}, 2'b10);
    chk(fault === 1'b0 && valid === 1'b0 && ovr === 8'd0, "R1 status in reset",
        {fault, valid, ovr}, 144'd0);
    nfr = 0;
    rst_n = 1'b1; armed = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1 && fault === 1'b0 && valid === 1'b0, "R1 after release",
        {cs_n, fault, valid}, 3'b100);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 6; k++) res_val[k] = '0;
    do_reset();

    // bring-up with clean diagnosis
    diag_val = 24'h0;
    pulse_drdy();                                  // R6: ignored before bring-up
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (300) @(negedge clk);
    @(negedge clk) start = 1'b1;                   // R10: second start ignored
    @(negedge clk) start = 1'b0;
    pulse_drdy();                                  // R6: ignored during bring-up
    wait_frames(40);
    repeat (600) @(negedge clk);
    chk(nfr == 40, "R10 R6 no extra frames after bring-up", 144'(nfr), 144'd40);
    chk(ovr == 8'd0, "R6 early data-ready not counted", 144'(ovr), 144'd0);
    chk(fault == 1'b0 && diag_word == 24'h0, "R5 clean diagnosis", {fault, diag_word}, 144'd0);
    for (int s = 0; s < 40; s++)
      chk(flog[s] == exp_boot(s), (s < 4) ? "R3 bring-up frame" : "R4 config frame",
          144'(flog[s]), 144'(exp_boot(s)));

    // table-driven readouts
    for (int s = 0; s < 4; s++) begin
      int base;
      int t;
      logic [143:0] expv;
      for (int k = 0; k < 6; k++) begin
        res_val[k] = VEC[(s * 2 + k) % 8][47:24];
        expv[k*24 +: 24] = VEC[(s * 2 + k) % 8][23:0];
      end
      rdy  = (s != 0);
      base = nfr;
      pulse_drdy();
      if (s == 2) begin
        repeat (40) @(negedge clk);
        pulse_drdy();                              // R9: overrun mid-read
      end
      t = 0;
      while (!valid && t < 5000) begin @(negedge clk); t++; end
      chk(valid === 1'b1, "R8 valid after readout", 144'(valid), 144'd1);
      chk(rdata == expv, "R7 sign-extended fields", rdata, expv);
      chk(nfr == base + 6, "R6 six reads per data-ready", 144'(nfr - base), 144'd6);
      for (int k = 0; k < 6; k++)
        chk(flog[base + k] == {8'(8'h2A + k), 24'h0}, "R6 read address order",
            144'(flog[base + k]), 144'({8'(8'h2A + k), 24'h0}));
      if (s == 0) begin
        logic [143:0] held;
        held = rdata;
        repeat (100) @(negedge clk);
        pulse_drdy();                              // R9: overrun while held
        repeat (200) @(negedge clk);
        chk(valid === 1'b1 && rdata == held, "R8 held under back-pressure", rdata, held);
        chk(nfr == base + 6, "R8 R9 no frame while held", 144'(nfr - base), 144'd6);
        chk(ovr == 8'd1, "R9 overrun while held", 144'(ovr), 144'd1);
        @(negedge clk) rdy = 1'b1;
        @(negedge clk) rdy = 1'b0;
        chk(valid === 1'b0, "R8 valid drops after accept", 144'(valid), 144'd0);
      end else begin
        @(negedge clk);
        @(negedge clk);
        chk(valid === 1'b0, "R8 accepted with ready high", 144'(valid), 144'd0);
      end
      if (s == 2) chk(ovr == 8'd2 && nfr == base + 6, "R9 overrun mid-read, no restart",
                      {ovr, 32'(nfr - base)}, {8'd2, 32'd6});
      repeat (20) @(negedge clk);
    end

    // faulty diagnosis
    rdy = 1'b0;
    do_reset();
    diag_val = 24'h000040;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_frames(4);
    repeat (1000) @(negedge clk);
    chk(fault === 1'b1, "R5 fault raised", 144'(fault), 144'd1);
    chk(diag_word == 24'h000040, "R5 diagnosis word shown", 144'(diag_word), 144'h40);
    chk(nfr == 4, "R5 sequence halted", 144'(nfr), 144'd4);
    pulse_drdy();
    repeat (300) @(negedge clk);
    chk(nfr == 4 && ovr == 8'd0, "R5 data-ready ignored after fault", {32'(nfr), ovr}, {32'd4, 8'd0});

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule